// File: doc/BRIEF.md
# Display Control Register Decoder

This block sits behind the control port of a graphics controller. Every 32-bit word written to that port carries a command number in its top byte, and the block turns each word into register updates. The updates land in a status word, in the display geometry registers (scan-out start corner, horizontal and vertical display span), or in a small readback register. That readback register answers information queries about the drawing-environment registers.

The drawing-environment bank (eight 32-bit entries) is loaded through a separate write port by the drawing engine. The control port can only reset it to its defaults and query it. A full-reset command restores every register to its power-on value. A full reset and a command-buffer reset are both signalled to the rest of the chip as one-cycle pulses. A geometry-update pulse tells the scan-out logic when a start, range or mode command has been taken.

All state is registered. The effect of a write shows on the outputs in the cycle after the clock edge that samples the write strobe.

Top module: `dispctl_decoder`

## Requirements
- R1: After the synchronous reset `rst`, `status` reads 0x14802000, `query_data` reads 0, all geometry outputs read 0 and all three pulse outputs are low.
- R2: Command 0x03 copies data bit 0 into status bit 23 (1 means the display is blanked) and leaves every other status bit unchanged.
- R3: Command 0x04 copies data bits 1:0 into status bits 30:29 (the transfer direction field) and leaves every other status bit unchanged.
- R4: Command 0x05 loads the display start X from data bits 9:0 and the start Y from data bits 18:10. It ignores data bits 23:19.
- R5: Command 0x06 loads the horizontal span start from data bits 11:0 and its end from bits 23:12. Command 0x07 loads the vertical span start from data bits 9:0 and its end from bits 19:10.
- R6: Command 0x08 rewrites status bits 22:16. Data bits 5:0 go to status bits 22:17, data bit 6 goes to status bit 16, and the other status bits are kept.
- R7: Commands 0x10 to 0x1F are queries keyed by data bits 3:0. Codes 2, 3 and 4 load `query_data` with environment entry (code & 7) ANDed with 0x000FFFFF. Code 5 loads it with entry 5 ANDed with 0x003FFFFF. Code 7 loads the value 2. Any other code leaves `query_data` unchanged.
- R8: For commands 0x02, 0x03, 0x04, 0x06, 0x07 and 0x08, a write whose full 32-bit word equals the last word accepted for that command number is dropped. A dropped write changes no output and raises no `geom_upd`. Command 0x05 is never dropped.
- R9: `geom_upd` is high for exactly the one cycle after each accepted command 0x05, 0x06, 0x07 or 0x08, and is low otherwise.
- R10: Command 0x00 restores the reset state of R1. It also loads every environment entry i with (0xE0+i) shifted left by 24 and forgets all remembered command words. `full_rst_pulse` and `cmdbuf_rst_pulse` are both high for the following cycle.
- R11: Command 0x01 raises only `cmdbuf_rst_pulse` for one cycle and leaves status, geometry and readback unchanged.
- R12: Commands 0x09 to 0x0F and 0x20 to 0xFF change nothing. A data word presented while `wr_en` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-port write strobe |
| wr_data | input | 32 | Control-port write word, command in bits 31:24 |
| env_we | input | 1 | Drawing-environment entry write strobe |
| env_idx | input | 3 | Drawing-environment entry index |
| env_data | input | 32 | Drawing-environment entry value |
| status | output | 32 | Status word |
| disp_x | output | 10 | Display start X |
| disp_y | output | 9 | Display start Y |
| hspan_start | output | 12 | Horizontal display span start |
| hspan_end | output | 12 | Horizontal display span end |
| vspan_start | output | 10 | Vertical display span start |
| vspan_end | output | 10 | Vertical display span end |
| query_data | output | 32 | Information query result |
| full_rst_pulse | output | 1 | One-cycle full reset indication |
| cmdbuf_rst_pulse | output | 1 | One-cycle command-buffer reset indication |
| geom_upd | output | 1 | One-cycle pulse after an accepted geometry or mode command |

## Verification
The decode is driven with data words whose fields are all ones next to non-zero junk bits, so a slice that is off by one bit or too wide shows up at once. Each status command is issued from a known status value and compared against a bench model, which separates a correct field update from one that disturbs neighbouring bits. Each geometry command is issued twice with the same word: the first write proves the capture, and the dropped repeat proves the duplicate filter. A full reset is placed between repeats to show that the remembered words are forgotten. Queries are run over every mask class and over codes that must leave the previous result in place, with and without stray bits above the code field.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int DATA_W = 32;
  localparam int CMD_W  = 8;

  localparam logic [CMD_W-1:0] OP_FULL_RST = 8'h00;
  localparam logic [CMD_W-1:0] OP_BUF_RST  = 8'h01;
  localparam logic [CMD_W-1:0] OP_BLANK    = 8'h03;
  localparam logic [CMD_W-1:0] OP_XFER_DIR = 8'h04;
  localparam logic [CMD_W-1:0] OP_START    = 8'h05;
  localparam logic [CMD_W-1:0] OP_HSPAN    = 8'h06;
  localparam logic [CMD_W-1:0] OP_VSPAN    = 8'h07;
  localparam logic [CMD_W-1:0] OP_MODE     = 8'h08;
  localparam logic [3:0]       OP_QUERY_HI = 4'h1;

  localparam logic [DATA_W-1:0] STATUS_INIT = 32'h1480_2000;
  localparam int BLANK_BIT = 23;
  localparam int DIR_LSB   = 29;
  localparam int MODE_LSB  = 16;
  localparam int MODE_W    = 7;

  localparam logic [DATA_W-1:0] MASK_NARROW = 32'h000F_FFFF;
  localparam logic [DATA_W-1:0] MASK_WIDE   = 32'h003F_FFFF;
  localparam logic [DATA_W-1:0] QUERY_VER   = 32'd2;

  typedef enum logic [1:0] {
    Q_NONE   = 2'd0,
    Q_NARROW = 2'd1,
    Q_WIDE   = 2'd2,
    Q_CONST  = 2'd3
  } query_kind_e;

  function automatic logic [DATA_W-1:0] env_default(input int idx);
    logic [CMD_W-1:0] tag;
    tag = CMD_W'(8'hE0 + idx);
    return {tag, {(DATA_W-CMD_W){1'b0}}};
  endfunction

  function automatic query_kind_e query_kind(input logic [3:0] code);
    case (code)
      4'd2, 4'd3, 4'd4: return Q_NARROW;
      4'd5:             return Q_WIDE;
      4'd7:             return Q_CONST;
      default:          return Q_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dcd_cmd_filter.sv
module dcd_cmd_filter
  import dcd_pkg::*;
#(
  parameter int SHADOW_N = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clear,
  output logic              accept
);
  localparam int IDX_W = $clog2(SHADOW_N);

  logic [DATA_W-1:0] shadow [SHADOW_N];
  logic [CMD_W-1:0]  cmd;
  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic              dup_checked;
  logic              same;

  assign cmd      = wr_data[DATA_W-1 -: CMD_W];
  assign in_range = (cmd < CMD_W'(SHADOW_N));
  assign idx      = in_range ? cmd[IDX_W-1:0] : '0;

  // Commands 2..8 except the start-position command are filtered.
  assign dup_checked = in_range && (cmd >= 8'd2) && (cmd != OP_START);
  assign same        = (shadow[idx] == wr_data);
  assign accept      = wr_en && !(dup_checked && same);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < SHADOW_N; i++) begin
        shadow[i] <= (i == 3) ? DATA_W'(1) : '0;
      end
    end else if (accept && in_range) begin
      shadow[idx] <= wr_data;
    end
  end
endmodule

// File: rtl/dcd_status_reg.sv
module dcd_status_reg
  import dcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              blank_en,
  input  logic              blank_val,
  input  logic              dir_en,
  input  logic [1:0]        dir_val,
  input  logic              mode_en,
  input  logic [MODE_W-1:0] mode_val,
  output logic [DATA_W-1:0] status
);
  logic [MODE_W-1:0] mode_bits;

  // Data bits 5:0 land above bit 6, which drops to the lowest position.
  assign mode_bits = {mode_val[MODE_W-2:0], mode_val[MODE_W-1]};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      status <= STATUS_INIT;
    end else begin
      if (blank_en) status[BLANK_BIT]             <= blank_val;
      if (dir_en)   status[DIR_LSB +: 2]          <= dir_val;
      if (mode_en)  status[MODE_LSB +: MODE_W]    <= mode_bits;
    end
  end
endmodule

// File: rtl/dcd_geom_regs.sv
module dcd_geom_regs #(
  parameter int SX_W  = 10,
  parameter int SY_W  = 9,
  parameter int HS_W  = 12,
  parameter int VS_W  = 10,
  parameter int ARG_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             start_en,
  input  logic             hspan_en,
  input  logic             vspan_en,
  input  logic [ARG_W-1:0] arg,
  output logic [SX_W-1:0]  disp_x,
  output logic [SY_W-1:0]  disp_y,
  output logic [HS_W-1:0]  hspan_start,
  output logic [HS_W-1:0]  hspan_end,
  output logic [VS_W-1:0]  vspan_start,
  output logic [VS_W-1:0]  vspan_end
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      disp_x      <= '0;
      disp_y      <= '0;
      hspan_start <= '0;
      hspan_end   <= '0;
      vspan_start <= '0;
      vspan_end   <= '0;
    end else begin
      if (start_en) begin
        disp_x <= arg[SX_W-1:0];
        disp_y <= arg[SX_W +: SY_W];
      end
      if (hspan_en) begin
        hspan_start <= arg[HS_W-1:0];
        hspan_end   <= arg[HS_W +: HS_W];
      end
      if (vspan_en) begin
        vspan_start <= arg[VS_W-1:0];
        vspan_end   <= arg[VS_W +: VS_W];
      end
    end
  end
endmodule

// File: rtl/dcd_env_query.sv
module dcd_env_query
  import dcd_pkg::*;
#(
  parameter int ENV_N = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     env_we,
  input  logic [$clog2(ENV_N)-1:0] env_idx,
  input  logic [DATA_W-1:0]        env_data,
  input  logic                     query_en,
  input  logic [3:0]               query_code,
  output logic [DATA_W-1:0]        query_data
);
  localparam int IDX_W = $clog2(ENV_N);

  logic [DATA_W-1:0] env [ENV_N];
  query_kind_e       kind;
  logic [DATA_W-1:0] picked;

  genvar g;
  generate
    for (g = 0; g < ENV_N; g++) begin : g_env
      always_ff @(posedge clk) begin
        if (rst || clear) begin
          env[g] <= env_default(g);
        end else if (env_we && (env_idx == IDX_W'(g))) begin
          env[g] <= env_data;
        end
      end
    end
  endgenerate

  assign kind   = query_kind(query_code);
  assign picked = env[query_code[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      query_data <= '0;
    end else if (query_en) begin
      case (kind)
        Q_NARROW: query_data <= picked & MASK_NARROW;
        Q_WIDE:   query_data <= picked & MASK_WIDE;
        Q_CONST:  query_data <= QUERY_VER;
        default:  query_data <= query_data;
      endcase
    end
  end
endmodule

// File: rtl/dispctl_decoder.sv
module dispctl_decoder
  import dcd_pkg::*;
#(
  parameter int ENV_N    = 8,
  parameter int SHADOW_N = 9,
  parameter int SX_W     = 10,
  parameter int SY_W     = 9,
  parameter int HS_W     = 12,
  parameter int VS_W     = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [31:0]              wr_data,
  input  logic                     env_we,
  input  logic [$clog2(ENV_N)-1:0] env_idx,
  input  logic [31:0]              env_data,
  output logic [31:0]              status,
  output logic [SX_W-1:0]          disp_x,
  output logic [SY_W-1:0]          disp_y,
  output logic [HS_W-1:0]          hspan_start,
  output logic [HS_W-1:0]          hspan_end,
  output logic [VS_W-1:0]          vspan_start,
  output logic [VS_W-1:0]          vspan_end,
  output logic [31:0]              query_data,
  output logic                     full_rst_pulse,
  output logic                     cmdbuf_rst_pulse,
  output logic                     geom_upd
);
  localparam int ARG_W = DATA_W - CMD_W;

  logic [CMD_W-1:0] cmd;
  logic             accept;
  logic             do_full;
  logic             do_buf;
  logic             do_blank;
  logic             do_dir;
  logic             do_start;
  logic             do_hspan;
  logic             do_vspan;
  logic             do_mode;
  logic             do_query;

  assign cmd = wr_data[DATA_W-1 -: CMD_W];

  dcd_cmd_filter #(.SHADOW_N(SHADOW_N)) u_filter (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .clear  (do_full),
    .accept (accept)
  );

  assign do_full  = wr_en  && (cmd == OP_FULL_RST);
  assign do_buf   = wr_en  && (cmd == OP_BUF_RST);
  assign do_blank = accept && (cmd == OP_BLANK);
  assign do_dir   = accept && (cmd == OP_XFER_DIR);
  assign do_start = accept && (cmd == OP_START);
  assign do_hspan = accept && (cmd == OP_HSPAN);
  assign do_vspan = accept && (cmd == OP_VSPAN);
  assign do_mode  = accept && (cmd == OP_MODE);
  assign do_query = wr_en  && (cmd[CMD_W-1:4] == OP_QUERY_HI);

  dcd_status_reg u_status (
    .clk      (clk),
    .rst      (rst),
    .clear    (do_full),
    .blank_en (do_blank),
    .blank_val(wr_data[0]),
    .dir_en   (do_dir),
    .dir_val  (wr_data[1:0]),
    .mode_en  (do_mode),
    .mode_val (wr_data[MODE_W-1:0]),
    .status   (status)
  );

  dcd_geom_regs #(
    .SX_W (SX_W),
    .SY_W (SY_W),
    .HS_W (HS_W),
    .VS_W (VS_W),
    .ARG_W(ARG_W)
  ) u_geom (
    .clk        (clk),
    .rst        (rst),
    .clear      (do_full),
    .start_en   (do_start),
    .hspan_en   (do_hspan),
    .vspan_en   (do_vspan),
    .arg        (wr_data[ARG_W-1:0]),
    .disp_x     (disp_x),
    .disp_y     (disp_y),
    .hspan_start(hspan_start),
    .hspan_end  (hspan_end),
    .vspan_start(vspan_start),
    .vspan_end  (vspan_end)
  );

  dcd_env_query #(.ENV_N(ENV_N)) u_query (
    .clk       (clk),
    .rst       (rst),
    .clear     (do_full),
    .env_we    (env_we),
    .env_idx   (env_idx),
    .env_data  (env_data),
    .query_en  (do_query),
    .query_code(wr_data[3:0]),
    .query_data(query_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      full_rst_pulse   <= 1'b0;
      cmdbuf_rst_pulse <= 1'b0;
      geom_upd         <= 1'b0;
    end else begin
      full_rst_pulse   <= do_full;
      cmdbuf_rst_pulse <= do_full || do_buf;
      geom_upd         <= do_start || do_hspan || do_vspan || do_mode;
    end
  end
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] status,
  input logic [11:0] hspan_start,
  input logic [11:0] hspan_end,
  input logic [31:0] query_data,
  input logic        full_rst_pulse,
  input logic        cmdbuf_rst_pulse,
  input logic        geom_upd
);
  assert_full_implies_buf_R10: assert property (@(posedge clk) disable iff (rst)
    full_rst_pulse |-> cmdbuf_rst_pulse);

  assert_full_pulse_cause_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (full_rst_pulse == ($past(wr_en) && ($past(wr_data[31:24]) == 8'h00))));

  assert_blank_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_data[31:24]) == 8'h03)
      |-> (status[23] == $past(wr_data[0])));

  assert_dir_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_data[31:24]) == 8'h04)
      |-> (status[30:29] == $past(wr_data[1:0])));

  assert_hspan_follow_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_data[31:24]) == 8'h06)
      |-> (hspan_start == $past(wr_data[11:0]) && hspan_end == $past(wr_data[23:12])));

  assert_query_const_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_data[31:28]) == 4'h1 && $past(wr_data[3:0]) == 4'h7)
      |-> (query_data == 32'd2));

  assert_geom_needs_write_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && geom_upd) |-> $past(wr_en));

  assert_status_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> $stable(status));
endmodule

bind dispctl_decoder dcd_checker u_dcd_checker (
  .clk             (clk),
  .rst             (rst),
  .wr_en           (wr_en),
  .wr_data         (wr_data),
  .status          (status),
  .hspan_start     (hspan_start),
  .hspan_end       (hspan_end),
  .query_data      (query_data),
  .full_rst_pulse  (full_rst_pulse),
  .cmdbuf_rst_pulse(cmdbuf_rst_pulse),
  .geom_upd        (geom_upd)
);

// File: tb/tb_dispctl_decoder.sv
module tb_dispctl_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        env_we;
  logic [2:0]  env_idx;
  logic [31:0] env_data;
  logic [31:0] status;
  logic [9:0]  disp_x;
  logic [8:0]  disp_y;
  logic [11:0] hspan_start, hspan_end;
  logic [9:0]  vspan_start, vspan_end;
  logic [31:0] query_data;
  logic        full_rst_pulse, cmdbuf_rst_pulse, geom_upd;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] exp_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  dispctl_decoder dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .env_we(env_we), .env_idx(env_idx), .env_data(env_data),
    .status(status), .disp_x(disp_x), .disp_y(disp_y),
    .hspan_start(hspan_start), .hspan_end(hspan_end),
    .vspan_start(vspan_start), .vspan_end(vspan_end),
    .query_data(query_data), .full_rst_pulse(full_rst_pulse),
    .cmdbuf_rst_pulse(cmdbuf_rst_pulse), .geom_upd(geom_upd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge take it, sample at the next falling edge.
  task automatic ctl_write(input logic [31:0] word);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = word;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 32'hA5A5_A5A5;
  endtask

  task automatic env_write(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    env_we = 1'b1; env_idx = idx; env_data = val;
    @(negedge clk);
    env_we = 1'b0;
  endtask

  task automatic test_reset_state;
    check("R1 status", status, 32'h1480_2000);
    check("R1 query", query_data, 32'h0);
    check("R1 geometry", {disp_x, disp_y, hspan_start}, 32'h0);
    check("R1 spans", {hspan_end, vspan_start, vspan_end}, 32'h0);
    check("R1 pulses", {29'h0, full_rst_pulse, cmdbuf_rst_pulse, geom_upd}, 32'h0);
    exp_status = 32'h1480_2000;
  endtask

  task automatic test_blank;
    ctl_write(32'h0300_0000);
    exp_status[23] = 1'b0;
    check("R2 unblank", status, exp_status);
    ctl_write(32'h03FF_FF01);
    exp_status[23] = 1'b1;
    check("R2 blank with junk bits", status, exp_status);
  endtask

  task automatic test_dir;
    ctl_write(32'h0400_0002);
    exp_status[30:29] = 2'b10;
    check("R3 dir 2", status, exp_status);
    ctl_write(32'h04FF_FFFD);
    exp_status[30:29] = 2'b01;
    check("R3 dir 1 with junk", status, exp_status);
  endtask

  task automatic test_start;
    ctl_write(32'h05FF_FFFF);
    check("R4 start x", {22'h0, disp_x}, 32'h3FF);
    check("R4 start y", {23'h0, disp_y}, 32'h1FF);
    check("R9 start pulse", {31'h0, geom_upd}, 32'h1);
    ctl_write(32'h05FF_FFFF);
    check("R8 start repeat not dropped", {31'h0, geom_upd}, 32'h1);
    ctl_write(32'h0500_0C01);
    check("R4 start x2", {22'h0, disp_x}, 32'h001);
    check("R4 start y2", {23'h0, disp_y}, 32'h003);
    @(negedge clk);
    check("R9 pulse drops", {31'h0, geom_upd}, 32'h0);
  endtask

  task automatic test_spans;
    ctl_write(32'h06AB_C123);
    check("R5 hspan start", {20'h0, hspan_start}, 32'h123);
    check("R5 hspan end", {20'h0, hspan_end}, 32'hABC);
    check("R9 hspan pulse", {31'h0, geom_upd}, 32'h1);
    ctl_write(32'h07F5_A9C3);
    check("R5 vspan start", {22'h0, vspan_start}, 32'h1C3);
    check("R5 vspan end", {22'h0, vspan_end}, 32'h16A);
  endtask

  task automatic test_mode;
    ctl_write(32'h0800_0055);
    exp_status[22:16] = 7'b0101011;
    check("R6 mode 0x55", status, exp_status);
    ctl_write(32'h08FF_FF80);
    exp_status[22:16] = 7'b0000000;
    check("R6 mode cleared, junk ignored", status, exp_status);
    ctl_write(32'h0800_0040);
    exp_status[22:16] = 7'b0000001;
    check("R6 bit6 to status16", status, exp_status);
  endtask

  task automatic test_duplicate;
    ctl_write(32'h0600_0111);
    check("R8 first hspan accepted", {31'h0, geom_upd}, 32'h1);
    ctl_write(32'h0600_0111);
    check("R8 repeat hspan dropped", {31'h0, geom_upd}, 32'h0);
    check("R8 hspan kept", {20'h0, hspan_start}, 32'h111);
    ctl_write(32'h0800_0040);
    check("R8 repeat mode dropped", {31'h0, geom_upd}, 32'h0);
    check("R8 status kept", status, exp_status);
  endtask

  task automatic test_query;
    env_write(3'd2, 32'hFFFF_FFFF);
    env_write(3'd3, 32'h1234_5678);
    env_write(3'd4, 32'hCAFE_BABE);
    env_write(3'd5, 32'hFFFF_FFFF);
    ctl_write(32'h1000_0002);
    check("R7 code2", query_data, 32'h000F_FFFF);
    ctl_write(32'h1A00_0003);
    check("R7 code3", query_data, 32'h0004_5678);
    ctl_write(32'h1000_0014);
    check("R7 code4 upper bits", query_data, 32'h000E_BABE);
    ctl_write(32'h1F00_0005);
    check("R7 code5", query_data, 32'h003F_FFFF);
    ctl_write(32'h1000_0007);
    check("R7 code7", query_data, 32'h0000_0002);
    ctl_write(32'h1000_000A);
    check("R7 code A unchanged", query_data, 32'h0000_0002);
    ctl_write(32'h1100_0000);
    check("R7 code 0 unchanged", query_data, 32'h0000_0002);
  endtask

  task automatic test_bufreset_and_unknown;
    ctl_write(32'h0100_0000);
    check("R11 buf pulse", {30'h0, full_rst_pulse, cmdbuf_rst_pulse}, 32'h1);
    check("R11 status kept", status, exp_status);
    check("R11 query kept", query_data, 32'h2);
    ctl_write(32'h09FF_FFFF);
    ctl_write(32'h20FF_FFFF);
    ctl_write(32'hFFFF_FFFF);
    check("R12 status kept", status, exp_status);
    check("R12 hspan kept", {20'h0, hspan_start}, 32'h111);
    check("R12 no pulses", {29'h0, full_rst_pulse, cmdbuf_rst_pulse, geom_upd}, 32'h0);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'h0000_0000;
    @(negedge clk);
    check("R12 no strobe no reset", {30'h0, full_rst_pulse, cmdbuf_rst_pulse}, 32'h0);
    check("R12 no strobe status", status, exp_status);
  endtask

  task automatic test_full_reset;
    ctl_write(32'h0000_0000);
    check("R10 both pulses", {30'h0, full_rst_pulse, cmdbuf_rst_pulse}, 32'h3);
    check("R10 status", status, 32'h1480_2000);
    check("R10 query cleared", query_data, 32'h0);
    check("R10 geometry", {disp_x, disp_y, hspan_start}, 32'h0);
    @(negedge clk);
    check("R10 pulse one cycle", {30'h0, full_rst_pulse, cmdbuf_rst_pulse}, 32'h0);
    ctl_write(32'h1000_0007);
    ctl_write(32'h1000_0005);
    check("R10 env5 default", query_data, 32'h0);
    ctl_write(32'h0600_0111);
    check("R10 remembered words forgotten", {31'h0, geom_upd}, 32'h1);
    check("R10 hspan reloaded", {20'h0, hspan_start}, 32'h111);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0;
    env_we = 1'b0; env_idx = '0; env_data = '0;
    exp_status = 32'h1480_2000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset_state();
    test_blank();
    test_dir();
    test_start();
    test_spans();
    test_mode();
    test_duplicate();
    test_query();
    test_bufreset_and_unknown();
    test_full_reset();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule